// File: doc/BRIEF.md
# Spindle Spin-Up Mode Sequencer

This controller-side state machine brings a sensorless spindle motor from rest up to regulated speed. It then releases the head actuator. It drives three mode-control lines toward an external power driver:

- **Spindle line.** A two-level line. High runs the spindle driver; low brakes it.
- **Commutation line.** A three-level line. Driven high or released (floating) selects hard commutation; driven low selects soft commutation.
- **Actuator line.** A two-level line. High enables the actuator driver; low disables it and parks the heads.

During start-up there is no back-EMF yet. The sequencer toggles the commutation line between driven-high and floating, and the driver uses this as its commutation clock. The first tachometer (FG) sample shows that the rotor is turning by itself, and the block moves to acceleration. Each FG period is then compared with a target period. A run of consecutive periods within ±1 % locks the speed: commutation turns soft and the actuator is enabled. A run of the same length outside the window drops the block back to acceleration. For reference, a motor with P poles at N rpm gives an FG rate of N·P/2·3/60 Hz; 5400 rpm with 8 poles gives 1080 Hz.

If start-up produces no FG sample in time, the block brakes briefly and retries. When the retry budget is spent, it latches a fault and keeps the brake applied. Dropping the start request returns the block to idle from any state.

Top module: `spinup_seq`

## Requirements
- R1: After reset the block is idle: mode code 0, spindle line low, commutation line driven high (output enable 1, value 1), actuator line low, retry count 0, fault low. Mode codes are: 0 idle, 1 start-up, 2 acceleration, 3 running, 4 brake, 5 fault.
- R2: In idle with the start request high, the block enters start-up (mode 1) on the next clock. In start-up the spindle line is high and the actuator line is low.
- R3: In start-up, cycle i after entry (counting from 0) drives the commutation line high when (i / STEP_CYC) is even and floats it (output enable 0) when it is odd. The line floats in no other mode.
- R4: An FG sample in start-up moves the block to acceleration (mode 2) on the next clock. In acceleration the commutation line is driven high, and the sample that ended start-up does not count toward lock.
- R5: If no FG sample arrives within STARTUP_CYC cycles of start-up while the retry count is below MAX_RETRY, the block enters brake (mode 4). The retry count goes up by one, all lines take their idle values for BRAKE_CYC cycles, and start-up then begins again.
- R6: An FG period P is in the window of target T exactly when 99·T ≤ 100·P ≤ 101·T.
- R7: In acceleration, LOCK_CNT consecutive in-window samples enter running (mode 3). Running drives the commutation line low and raises the actuator line. An out-of-window sample restarts the count.
- R8: In running, LOCK_CNT consecutive out-of-window samples return the block to acceleration, with the actuator line low. An in-window sample restarts that count.
- R9: The actuator line is high only when the spindle line is high and the commutation line is driven low.
- R10: A start-up timeout with the retry count already at MAX_RETRY enters fault (mode 5). In fault, fault is high, the lines hold their idle values, and FG samples have no effect while the start request stays high.
- R11: With the start request low, the block is idle on the next clock from any state, with the retry count and fault cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req_i | input | 1 | Spin-up request; low returns to idle |
| fg_valid_i | input | 1 | One-cycle strobe: a new FG period is present |
| fg_period_i | input | PERIOD_W | Measured FG period |
| target_period_i | input | PERIOD_W | FG period at the target speed |
| spin_en_o | output | 1 | Spindle line: 1 run, 0 brake |
| comm_val_o | output | 1 | Commutation line value when driven |
| comm_oe_o | output | 1 | Commutation line output enable; 0 floats it |
| act_en_o | output | 1 | Actuator line: 1 enable, 0 retract |
| mode_o | output | 3 | Mode code |
| retry_cnt_o | output | clog2(MAX_RETRY+2) | Start-up retries since the last idle |
| fault_o | output | 1 | Retry budget exhausted |

## Verification
A wrong state shows up at once on the line pins, because the line values are decoded directly from the state register. A stuck or misaligned start-up divider shows as a floating phase in the wrong cycle; the bench compares the output enable in every start-up cycle of every attempt. A streak counter that keeps stale counts shows as a lock or drop one or two FG samples too early or too late. The window sweep is run on two targets, one round and one not, so an off-by-one bound flips the mode on the very next lock attempt.

// File: rtl/spinup_pkg.sv
package spinup_pkg;

    localparam int MAX_PERIOD_W = 24;

    typedef enum logic [2:0] {
        MODE_IDLE    = 3'd0,
        MODE_STARTUP = 3'd1,
        MODE_ACCEL   = 3'd2,
        MODE_RUN     = 3'd3,
        MODE_BRAKE   = 3'd4,
        MODE_FAULT   = 3'd5
    } spin_mode_e;

    typedef struct packed {
        logic spin_en;
        logic comm_val;
        logic comm_oe;
        logic act_en;
    } ctl_lines_t;

    // exact ±1 % window without division: 99*T <= 100*P <= 101*T
    function automatic logic period_in_window(input logic [MAX_PERIOD_W-1:0] p,
                                              input logic [MAX_PERIOD_W-1:0] t);
        logic [MAX_PERIOD_W+7:0] scaled_p;
        logic [MAX_PERIOD_W+7:0] lo_lim;
        logic [MAX_PERIOD_W+7:0] hi_lim;
        scaled_p = (MAX_PERIOD_W+8)'(p) * (MAX_PERIOD_W+8)'(100);
        lo_lim   = (MAX_PERIOD_W+8)'(t) * (MAX_PERIOD_W+8)'(99);
        hi_lim   = (MAX_PERIOD_W+8)'(t) * (MAX_PERIOD_W+8)'(101);
        return (scaled_p >= lo_lim) && (scaled_p <= hi_lim);
    endfunction

    // line values per mode; drive_phase selects high/float during start-up
    function automatic ctl_lines_t lines_for_mode(input spin_mode_e m, input logic drive_phase);
        ctl_lines_t l;
        l = '{spin_en: 1'b0, comm_val: 1'b1, comm_oe: 1'b1, act_en: 1'b0};
        case (m)
            MODE_STARTUP: begin
                l.spin_en = 1'b1;
                l.comm_oe = drive_phase;
            end
            MODE_ACCEL: l.spin_en = 1'b1;
            MODE_RUN: begin
                l.spin_en  = 1'b1;
                l.comm_val = 1'b0;
                l.act_en   = 1'b1;
            end
            default: ;
        endcase
        return l;
    endfunction

endpackage

// File: rtl/spinup_timer.sv
module spinup_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    output logic [W-1:0] cnt_o
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_o <= '0;
        end else if (cnt_o != {W{1'b1}}) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end

    AST_TMR_CLEAR: assert property (@(posedge clk) disable iff (rst) clr |=> (cnt_o == '0)) else $error("timer clear"); // R5
endmodule

// File: rtl/spinup_comm_clk.sv
module spinup_comm_clk #(
    parameter int STEP_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic phase_o
);
    generate
        if (STEP_CYC <= 1) begin : g_every_cycle
            always_ff @(posedge clk) begin
                if (rst || !en) phase_o <= 1'b1;
                else            phase_o <= ~phase_o;
            end
        end else begin : g_divided
            localparam int CW = $clog2(STEP_CYC);
            logic [CW-1:0] step_cnt;
            always_ff @(posedge clk) begin
                if (rst || !en) begin
                    step_cnt <= '0;
                    phase_o  <= 1'b1;
                end else if (step_cnt == CW'(STEP_CYC - 1)) begin
                    step_cnt <= '0;
                    phase_o  <= ~phase_o;
                end else begin
                    step_cnt <= step_cnt + 1'b1;
                end
            end
        end
    endgenerate

    AST_PHASE_REST: assert property (@(posedge clk) disable iff (rst) !en |=> phase_o) else $error("phase not at rest"); // R3
endmodule

// File: rtl/spinup_lock_det.sv
module spinup_lock_det
    import spinup_pkg::*;
#(
    parameter int PERIOD_W = 16,
    parameter int LOCK_CNT = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic                sample_valid,
    input  logic [PERIOD_W-1:0] period,
    input  logic [PERIOD_W-1:0] target,
    output logic                locked_o,
    output logic                lost_o
);
    localparam int CW = $clog2(LOCK_CNT + 1);
    localparam logic [CW-1:0] FULL = CW'(LOCK_CNT);

    logic [CW-1:0] in_run;
    logic [CW-1:0] out_run;
    logic          inwin;

    assign inwin = period_in_window(MAX_PERIOD_W'(period), MAX_PERIOD_W'(target));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            in_run  <= '0;
            out_run <= '0;
        end else if (sample_valid) begin
            if (inwin) begin
                out_run <= '0;
                if (in_run != FULL) in_run <= in_run + 1'b1;
            end else begin
                in_run <= '0;
                if (out_run != FULL) out_run <= out_run + 1'b1;
            end
        end
    end

    assign locked_o = (in_run == FULL);
    assign lost_o   = (out_run == FULL);

    AST_STREAK_EXCL: assert property (@(posedge clk) disable iff (rst) !(locked_o && lost_o)) else $error("both streaks full"); // R7
    AST_STREAK_HOLD: assert property (@(posedge clk) disable iff (rst) (!sample_valid && !clr) |=> ($stable(in_run) && $stable(out_run))) else $error("streak moved without sample"); // R8
endmodule

// File: rtl/spinup_seq.sv
module spinup_seq
    import spinup_pkg::*;
#(
    parameter int PERIOD_W    = 16,
    parameter int STEP_CYC    = 4,
    parameter int STARTUP_CYC = 40,
    parameter int BRAKE_CYC   = 6,
    parameter int LOCK_CNT    = 3,
    parameter int MAX_RETRY   = 2
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              start_req_i,
    input  logic                              fg_valid_i,
    input  logic [PERIOD_W-1:0]               fg_period_i,
    input  logic [PERIOD_W-1:0]               target_period_i,
    output logic                              spin_en_o,
    output logic                              comm_val_o,
    output logic                              comm_oe_o,
    output logic                              act_en_o,
    output logic [2:0]                        mode_o,
    output logic [$clog2(MAX_RETRY+2)-1:0]    retry_cnt_o,
    output logic                              fault_o
);
    localparam int RW     = $clog2(MAX_RETRY + 2);
    localparam int LONGEST = (STARTUP_CYC > BRAKE_CYC) ? STARTUP_CYC : BRAKE_CYC;
    localparam int TW     = $clog2(LONGEST + 1);
    localparam logic [TW-1:0] STARTUP_LAST = TW'(STARTUP_CYC - 1);
    localparam logic [TW-1:0] BRAKE_LAST   = TW'(BRAKE_CYC - 1);
    localparam logic [RW-1:0] RETRY_LIMIT  = RW'(MAX_RETRY);

    spin_mode_e     state_q, state_d;
    logic [RW-1:0]  retry_q, retry_d;
    logic [TW-1:0]  tmr_cnt;
    logic           drive_phase;
    logic           locked, lost;
    ctl_lines_t     lines;

    spinup_timer #(.W(TW)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clr   (state_d != state_q),
        .cnt_o (tmr_cnt)
    );

    spinup_comm_clk #(.STEP_CYC(STEP_CYC)) u_comm_clk (
        .clk     (clk),
        .rst     (rst),
        .en      (state_q == MODE_STARTUP),
        .phase_o (drive_phase)
    );

    spinup_lock_det #(.PERIOD_W(PERIOD_W), .LOCK_CNT(LOCK_CNT)) u_lock (
        .clk          (clk),
        .rst          (rst),
        .clr          (!(state_q == MODE_ACCEL || state_q == MODE_RUN)),
        .sample_valid (fg_valid_i),
        .period       (fg_period_i),
        .target       (target_period_i),
        .locked_o     (locked),
        .lost_o       (lost)
    );

    always_comb begin
        state_d = state_q;
        retry_d = retry_q;
        if (!start_req_i) begin
            state_d = MODE_IDLE;
            retry_d = '0;
        end else begin
            case (state_q)
                MODE_IDLE: state_d = MODE_STARTUP;
                MODE_STARTUP: begin
                    if (fg_valid_i) begin
                        state_d = MODE_ACCEL;
                    end else if (tmr_cnt == STARTUP_LAST) begin
                        if (retry_q == RETRY_LIMIT) begin
                            state_d = MODE_FAULT;
                        end else begin
                            state_d = MODE_BRAKE;
                            retry_d = retry_q + 1'b1;
                        end
                    end
                end
                MODE_BRAKE: if (tmr_cnt == BRAKE_LAST) state_d = MODE_STARTUP;
                MODE_ACCEL: if (locked) state_d = MODE_RUN;
                MODE_RUN:   if (lost) state_d = MODE_ACCEL;
                MODE_FAULT: state_d = MODE_FAULT;
                default:    state_d = MODE_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= MODE_IDLE;
            retry_q <= '0;
        end else begin
            state_q <= state_d;
            retry_q <= retry_d;
        end
    end

    assign lines       = lines_for_mode(state_q, drive_phase);
    assign spin_en_o   = lines.spin_en;
    assign comm_val_o  = lines.comm_val;
    assign comm_oe_o   = lines.comm_oe;
    assign act_en_o    = lines.act_en;
    assign mode_o      = state_q;
    assign retry_cnt_o = retry_q;
    assign fault_o     = (state_q == MODE_FAULT);

    AST_ACT_NEEDS_SOFT: assert property (@(posedge clk) disable iff (rst) act_en_o |-> (spin_en_o && comm_oe_o && !comm_val_o)) else $error("actuator early"); // R9
    AST_FLOAT_STARTUP: assert property (@(posedge clk) disable iff (rst) !comm_oe_o |-> (mode_o == 3'd1)) else $error("float outside start-up"); // R3
    AST_FAULT_BRAKED: assert property (@(posedge clk) disable iff (rst) fault_o |-> (!spin_en_o && !act_en_o && comm_oe_o)) else $error("fault not braked"); // R10
    AST_RETRY_BOUND: assert property (@(posedge clk) disable iff (rst) retry_cnt_o <= RETRY_LIMIT) else $error("retry overflow"); // R5
    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (rst) !start_req_i |=> (mode_o == 3'd0 && retry_cnt_o == '0)) else $error("stop not idle"); // R11
    AST_BRAKE_ENTRY: assert property (@(posedge clk) disable iff (rst) (state_q == MODE_BRAKE && $past(state_q) != MODE_BRAKE) |-> ($past(state_q) == MODE_STARTUP)) else $error("brake entry"); // R5
    AST_RUN_ENTRY: assert property (@(posedge clk) disable iff (rst) (state_q == MODE_RUN && $past(state_q) != MODE_RUN) |-> ($past(state_q) == MODE_ACCEL)) else $error("run entry"); // R7
endmodule

// File: tb/spinup_seq_tb.sv
module spinup_seq_tb_top;
    localparam int PW = 16, STEP = 4, SCYC = 40, BCYC = 6, LCNT = 3, MR = 2;

    logic clk = 1'b0, rst = 1'b1, start_req = 1'b0, fg_valid = 1'b0;
    logic [PW-1:0] fg_period = '0, target = 16'd1000;
    logic spin_en, comm_val, comm_oe, act_en, fault;
    logic [2:0] mode;
    logic [$clog2(MR+2)-1:0] retry_cnt;
    int checks = 0, failures = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    spinup_seq #(.PERIOD_W(PW), .STEP_CYC(STEP), .STARTUP_CYC(SCYC), .BRAKE_CYC(BCYC),
                 .LOCK_CNT(LCNT), .MAX_RETRY(MR)) dut_i (
        .clk(clk), .rst(rst), .start_req_i(start_req), .fg_valid_i(fg_valid),
        .fg_period_i(fg_period), .target_period_i(target), .spin_en_o(spin_en),
        .comm_val_o(comm_val), .comm_oe_o(comm_oe), .act_en_o(act_en), .mode_o(mode),
        .retry_cnt_o(retry_cnt), .fault_o(fault));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // one FG strobe; returns after the mode has had a clock to react
    task automatic send(input int p);
        @(negedge clk); fg_valid = 1'b1; fg_period = PW'(p);
        @(negedge clk); fg_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic lines_idle(input string req);
        chk({req, " spin"}, spin_en, 0);
        chk({req, " oe"}, comm_oe, 1);
        chk({req, " val"}, comm_val, 1);
        chk({req, " act"}, act_en, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 mode", mode, 0); lines_idle("R1");
        chk("R1 retry", retry_cnt, 0); chk("R1 fault", fault, 0);

        // R2/R3/R5/R10: three attempts with no FG
        @(negedge clk); start_req = 1'b1;
        for (int a = 0; a <= MR; a++) begin
            for (int i = 0; i < SCYC; i++) begin
                @(negedge clk);
                chk("R2 mode", mode, 1);
                if (i == 0) begin chk("R2 spin", spin_en, 1); chk("R2 act", act_en, 0); end
                chk("R3 oe", comm_oe, ((i / STEP) % 2 == 0) ? 1 : 0);
            end
            @(negedge clk);
            if (a < MR) begin
                chk("R5 mode", mode, 4); chk("R5 retry", retry_cnt, a + 1); lines_idle("R5");
                for (int j = 1; j < BCYC; j++) begin
                    @(negedge clk); chk("R5 hold", mode, 4);
                end
            end else begin
                chk("R10 mode", mode, 5); chk("R10 fault", fault, 1);
                chk("R10 retry", retry_cnt, MR); lines_idle("R10");
            end
        end
        send(1000);
        repeat (5) @(negedge clk);
        chk("R10 stays", mode, 5); lines_idle("R10 fg");

        start_req = 1'b0;
        @(negedge clk);
        chk("R11 mode", mode, 0); chk("R11 fault", fault, 0); chk("R11 retry", retry_cnt, 0);

        // R4: FG ends start-up, that sample is not counted
        start_req = 1'b1;
        @(negedge clk);
        send(1000);
        chk("R4 mode", mode, 2); chk("R4 oe", comm_oe, 1); chk("R4 val", comm_val, 1); chk("R4 act", act_en, 0);
        send(1000); send(1000);
        chk("R4 not counted", mode, 2);
        send(1000);
        chk("R7 lock", mode, 3); chk("R7 act", act_en, 1); chk("R7 val", comm_val, 0); chk("R7 oe", comm_oe, 1);

        // R8 drop with reset of out-streak
        send(2000); send(2000); send(1000); send(2000); send(2000);
        chk("R8 streak reset", mode, 3);
        send(2000);
        chk("R8 drop", mode, 2); chk("R8 act", act_en, 0); chk("R8 val", comm_val, 1);

        // R7 in-streak reset by an outlier
        send(1000); send(1000); send(2000); send(1000); send(1000);
        chk("R7 streak reset", mode, 2);
        send(1000);
        chk("R7 relock", mode, 3);
        send(2000); send(2000); send(2000);
        chk("R8 back", mode, 2);

        // R6 window sweep on two targets
        for (int k = 0; k < 2; k++) begin
            int t;
            t = (k == 0) ? 1000 : 997;
            target = PW'(t);
            for (int p = t - 15; p <= t + 15; p++) begin
                bit inw;
                inw = (p * 100 >= t * 99) && (p * 100 <= t * 101);
                send(p); send(p); send(p);
                chk($sformatf("R6 t=%0d p=%0d", t, p), mode, inw ? 3 : 2);
                if (mode == 3'd3) begin
                    send(2 * t); send(2 * t); send(2 * t);
                    chk("R8 sweep drop", mode, 2);
                end
            end
        end

        // R11 from running
        target = 16'd1000;
        send(1000); send(1000); send(1000);
        chk("R9 run act", act_en, 1);
        start_req = 1'b0;
        @(negedge clk);
        chk("R11 from run", mode, 0); lines_idle("R11");
        finish_run();
    end
endmodule